// File: doc/BRIEF.md
# Buffered External Event Counter

This block counts edges on an asynchronous event input. The event input first passes through a synchronizer. An edge detector then turns the chosen transitions into single-cycle count strobes. While the enable input is low, the counter rests at all ones. When the enable input rises, the counter steps to zero. In the same cycle, the programmed compare value is copied into a shadow buffer, and the match logic reads only that buffer.

Each valid edge then adds one to the count. Once the count equals the buffered compare value, the next valid edge wraps the count to zero and raises a one-cycle match interrupt. An interrupt therefore arrives once every (compare + 1) edges. Software-side writes to the compare register can be made at any time. They reach the match logic only at the next enable rise, so a running period is never disturbed part-way through.

Top module: `ext_event_counter`

## Requirements
- R1: After reset the count output is all ones (FFFFH), the interrupt is low and the compare register and its buffer hold zero.
- R2: While count_en is low, the count output holds FFFFH and edges on event_in have no effect on it.
- R3: On the first clock edge at which count_en is seen high after being low, the count becomes 0000H and the buffer takes the compare register value. If cmp_wr is high in that same cycle, the buffer takes cmp_wdata instead. An event edge arriving in that cycle is not counted.
- R4: edge_sel encoding: 2'b00 counts nothing, 2'b01 counts rising edges, 2'b10 counts falling edges, 2'b11 counts both.
- R5: event_in passes through two synchronizer flops and one history flop. A level change sampled at one clock edge shows in count_val after the third clock edge counted from that sampling edge. At most one count is taken per clock.
- R6: While enabled, each valid edge raises the count by exactly one, unless R7 applies.
- R7: While enabled, a valid edge that arrives while the count equals the buffer clears the count to 0000H. In that same cycle match_irq is high for one clock, and match_irq is never high with a nonzero count.
- R8: After an enable rise, match_irq fires once every (buffer + 1) valid edges. After N edges the count reads N mod (buffer + 1).
- R9: Writes to the compare register while counting is enabled leave the buffer unchanged until the next enable rise.
- R10: A clock edge with count_en low forces the count to FFFFH and match_irq low, even if a count strobe is due at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_en | input | 1 | Counting enable; its rise reloads the buffer and zeroes the count |
| edge_sel | input | 2 | Valid-edge selection (none / rising / falling / both) |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | 16 | Compare register write data |
| event_in | input | 1 | Asynchronous external event input |
| count_val | output | 16 | Current count |
| match_irq | output | 1 | One-cycle compare-match interrupt pulse |

## Verification
An event level change affects count_val after the third rising edge counted from the edge that samples it. The bench drives on falling edges, so after an event toggle it waits three full cycles before sampling. A change of count_en reaches the count after one edge, so enable and disable results are sampled at the next falling edge. The interrupt is tallied on every falling edge and compared with the number of edges divided by (compare + 1). The R5 check deliberately samples after two edges, where the count must still be the old value, and again after the third edge.

// File: rtl/ext_event_pkg.sv
package ext_event_pkg;
   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;
endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/evc_edge_detect.sv
module evc_edge_detect
   import ext_event_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       level_in,
   input  logic [1:0] edge_sel,
   output logic       edge_stb
);
   logic      hist_q;
   logic      rise_w;
   logic      fall_w;
   edge_sel_e sel_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= 1'b0;
      else        hist_q <= level_in;
   end

   assign rise_w = level_in & ~hist_q;
   assign fall_w = ~level_in & hist_q;
   assign sel_w  = edge_sel_e'(edge_sel);

   always_comb begin
      case (sel_w)
         EDGE_RISE: edge_stb = rise_w;
         EDGE_FALL: edge_stb = fall_w;
         EDGE_BOTH: edge_stb = rise_w | fall_w;
         default:   edge_stb = 1'b0;
      endcase
   end
endmodule

// File: rtl/evc_cmp_store.sv
module evc_cmp_store #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             load,
   output logic [CNT_W-1:0] buf_val
);
   logic [CNT_W-1:0] reg_q;
   logic [CNT_W-1:0] buf_q;
   logic [CNT_W-1:0] reg_view;

   assign reg_view = wr_en ? wr_data : reg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q <= '0;
         buf_q <= '0;
      end else begin
         if (wr_en) reg_q <= wr_data;
         if (load)  buf_q <= reg_view;
      end
   end

   assign buf_val = buf_q;
endmodule

// File: rtl/evc_count_core.sv
module evc_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             step,
   input  logic [CNT_W-1:0] limit,
   output logic             load_buf,
   output logic [CNT_W-1:0] count,
   output logic             irq
);
   localparam logic [CNT_W-1:0] IDLE_VAL = {CNT_W{1'b1}};

   logic             en_q;
   logic [CNT_W-1:0] cnt_q;
   logic             irq_q;
   logic             hit_w;
   logic             run_w;

   assign load_buf = enable & ~en_q;
   assign run_w    = enable & en_q;
   assign hit_w    = (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         cnt_q <= IDLE_VAL;
         irq_q <= 1'b0;
      end else begin
         en_q  <= enable;
         irq_q <= 1'b0;
         if (!enable) begin
            cnt_q <= IDLE_VAL;
         end else if (load_buf) begin
            cnt_q <= '0;
         end else if (run_w && step) begin
            if (hit_w) begin
               cnt_q <= '0;
               irq_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign count = cnt_q;
   assign irq   = irq_q;
endmodule

// File: rtl/ext_event_counter.sv
module ext_event_counter #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_en,
   input  logic [1:0]       edge_sel,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic             event_in,
   output logic [CNT_W-1:0] count_val,
   output logic             match_irq
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("ext_event_counter: CNT_W must lie in 2..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ext_event_counter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             ev_sync;
   logic             ev_stb;
   logic             load_w;
   logic [CNT_W-1:0] buf_w;

   evc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (event_in),
      .sync_out (ev_sync)
   );

   evc_edge_detect u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (ev_sync),
      .edge_sel (edge_sel),
      .edge_stb (ev_stb)
   );

   evc_cmp_store #(.CNT_W(CNT_W)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cmp_wr),
      .wr_data (cmp_wdata),
      .load    (load_w),
      .buf_val (buf_w)
   );

   evc_count_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (count_en),
      .step     (ev_stb),
      .limit    (buf_w),
      .load_buf (load_w),
      .count    (count_val),
      .irq      (match_irq)
   );
endmodule

// File: rtl/ext_event_counter_chk.sv
module ext_event_counter_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             count_en,
   input logic [CNT_W-1:0] count_val,
   input logic             match_irq
);
   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   assert_idle_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !count_en |=> (count_val == ALL_ONES));

   assert_start_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(count_en) |=> (count_val == '0) && !match_irq);

   assert_step_by_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (count_val != $past(count_val)) && (count_val != '0) && (count_val != ALL_ONES)
      |-> (count_val == $past(count_val) + 1'b1));

   assert_irq_with_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      match_irq |-> (count_val == '0));

   assert_irq_off_when_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !count_en |=> !match_irq);
endmodule

bind ext_event_counter ext_event_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .count_en  (count_en),
   .count_val (count_val),
   .match_irq (match_irq)
);

// File: tb/ext_event_counter_bench.sv
module ext_event_counter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        count_en = 1'b0;
   logic [1:0]  edge_sel = 2'b00;
   logic        cmp_wr = 1'b0;
   logic [15:0] cmp_wdata = '0;
   logic        event_in = 1'b0;
   logic [15:0] count_val;
   logic        match_irq;

   int n_checks = 0;
   int n_fail   = 0;
   int irq_seen = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   ext_event_counter u_ext_event_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .count_en  (count_en),
      .edge_sel  (edge_sel),
      .cmp_wr    (cmp_wr),
      .cmp_wdata (cmp_wdata),
      .event_in  (event_in),
      .count_val (count_val),
      .match_irq (match_irq)
   );

   always @(negedge clk) if (rst_n && match_irq) irq_seen++;

   // stimulus vectors: {edge_sel, compare, pulses}
   localparam int NVEC = 6;
   localparam logic [33:0] VEC [NVEC] = '{
      {2'b01, 16'd3, 16'd10},
      {2'b10, 16'd4, 16'd7},
      {2'b11, 16'd2, 16'd5},
      {2'b00, 16'd1, 16'd4},
      {2'b01, 16'd0, 16'd3},
      {2'b11, 16'd6, 16'd3}
   };

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse();
      event_in = 1'b1; cycles(3);
      event_in = 1'b0; cycles(3);
   endtask

   task automatic start(input logic [1:0] sel, input logic [15:0] cmp);
      count_en = 1'b0; edge_sel = sel;
      cycles(1);
      cmp_wr = 1'b1; cmp_wdata = cmp;
      cycles(1);
      cmp_wr = 1'b0; count_en = 1'b1;
      cycles(1);
      irq_seen = 0;
   endtask

   function automatic int edges_per_pulse(input logic [1:0] sel);
      case (sel)
         2'b01, 2'b10: return 1;
         2'b11:        return 2;
         default:      return 0;
      endcase
   endfunction

   initial begin
      cycles(2);
      check("R1 reset count", count_val, 16'hFFFF);
      check("R1 reset irq", match_irq, 0);
      rst_n = 1'b1;
      cycles(1);

      // R2: edges while disabled
      edge_sel = 2'b11;
      pulse(); pulse();
      check("R2 disabled count", count_val, 16'hFFFF);
      check("R2 disabled irq", irq_seen, 0);

      // vector table: R4, R6, R7, R8
      for (int v = 0; v < NVEC; v++) begin
         logic [1:0]  sel;
         logic [15:0] cmp;
         logic [15:0] np;
         int          ne;
         {sel, cmp, np} = VEC[v];
         start(sel, cmp);
         check("R3 start zero", count_val, 0);
         for (int p = 0; p < int'(np); p++) pulse();
         cycles(2);
         ne = int'(np) * edges_per_pulse(sel);
         check("R4/R8 count", count_val, ne % (int'(cmp) + 1));
         check("R7/R8 irq count", irq_seen, ne / (int'(cmp) + 1));
      end

      // R5: latency of three edges
      start(2'b01, 16'd100);
      event_in = 1'b1;
      cycles(2);
      check("R5 not yet counted", count_val, 0);
      cycles(1);
      check("R5 counted after third edge", count_val, 1);
      event_in = 1'b0; cycles(3);

      // R9: write while enabled does not reach buffer
      start(2'b01, 16'd2);
      cmp_wr = 1'b1; cmp_wdata = 16'd0; cycles(1); cmp_wr = 1'b0;
      pulse();
      check("R9 old buffer kept", count_val, 1);
      check("R9 no early irq", irq_seen, 0);
      pulse(); pulse();
      check("R9 irq at old compare", irq_seen, 1);
      check("R9 wrapped count", count_val, 0);
      // re-enable picks the written zero
      count_en = 1'b0; cycles(1);
      check("R10 disable gives FFFF", count_val, 16'hFFFF);
      count_en = 1'b1; cycles(1);
      irq_seen = 0;
      pulse();
      check("R9 new buffer after re-enable", irq_seen, 1);

      // R3: same-cycle write forwarded into buffer
      count_en = 1'b0; edge_sel = 2'b01; cycles(1);
      cmp_wr = 1'b1; cmp_wdata = 16'd1; count_en = 1'b1;
      cycles(1);
      cmp_wr = 1'b0; irq_seen = 0;
      pulse();
      check("R3 forwarded compare count", count_val, 1);
      pulse();
      check("R3 forwarded compare irq", irq_seen, 1);

      // R10: disable just before a due step suppresses irq
      start(2'b11, 16'd0);
      event_in = 1'b1;
      cycles(2);
      count_en = 1'b0;
      cycles(1);
      check("R10 irq suppressed", irq_seen, 0);
      check("R10 count idle", count_val, 16'hFFFF);
      event_in = 1'b0; cycles(4);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule